// File: doc/BRIEF.md
# Two-Thread Partitioned Reorder Buffer

This block tracks in-flight instructions for a core that runs two hardware threads. Its entries are split statically into one private circular region per thread. Each region has its own head and tail, so an unfinished instruction at the head of one thread's region never holds up retirement in the other thread. The front end allocates entries, tagging each with a thread number. Execution units mark entries finished by giving their index. The block then retires finished entries from each region's head, in program order for each thread.

A mode input selects dual-thread or single-thread operation. In dual mode each thread owns half of the entries. In single mode thread 0 owns every entry, and thread 1 is held full and empty. The block takes a new mode only when it holds no entries. The block does not store data values, and it does not handle exceptions or flushes.

Top module: `tt_part_rob`

## Requirements
- R1: After reset, both threads report empty, neither reports full, no commit is offered, and the block is in dual mode.
- R2: In dual mode each thread holds at most 8 entries. Thread 0 is given indices 0 to 7 and thread 1 indices 8 to 15. An allocation to a thread whose full flag is high is refused (alloc_accept low).
- R3: An entry commits only once it has been marked complete and every older entry of the same thread has committed. Commits appear in allocation order for each thread.
- R4: An uncompleted head entry in one thread does not stop the other thread from committing.
- R5: Each thread commits at most one entry per cycle, and both threads may commit in the same cycle.
- R6: In single mode thread 0 holds up to 16 entries, with indices 0 to 15. Thread 1 reports full and empty, and allocations to thread 1 are refused.
- R7: The mode input is taken only in a cycle where both threads are empty and no allocation is requested. Changing it while entries are held has no effect until the buffer drains.
- R8: Each thread's indices wrap within its own region, going from the region's last index back to its first. After a mode change, every region starts again at its first index.
- R9: A completion naming an entry that is not allocated is ignored. A later allocation of that index does not commit until it is itself completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_mode | input | 1 | Requested mode: 1 gives all entries to thread 0 |
| alloc_valid | input | 1 | Allocation request |
| alloc_tid | input | 1 | Thread of the allocation |
| alloc_accept | output | 1 | Request taken this cycle |
| alloc_idx | output | 4 | Entry index given to the request |
| cmpl_valid | input | 1 | Completion writeback |
| cmpl_idx | input | 4 | Entry index being completed |
| commit_valid | output | 2 | Per-thread commit this cycle (bit t is thread t) |
| commit_idx | output | 8 | Per-thread committing index, thread t in bits [4t+3:4t] |
| thr_full | output | 2 | Per-thread region full |
| thr_empty | output | 2 | Per-thread region empty |

## Verification
The bench builds the block with the default depth of 16, so each half-region holds 8 entries. Filling either thread to its limit, wrapping it, and filling the whole buffer in single mode therefore all take only a few dozen cycles. With regions this small, the bench can drive every boundary: a full refusal, a wrap from index 7 to 0 or from 15 to 8, and the final slot of the single-mode buffer. Completions are issued out of order to hold one thread's head back while the other thread retires.

// File: rtl/tt_rob_pkg.sv
package tt_rob_pkg;

    typedef enum logic {
        ROB_MODE_DUAL   = 1'b0,
        ROB_MODE_SINGLE = 1'b1
    } rob_mode_e;

    localparam int unsigned ROB_THREADS = 2;

endpackage

// File: rtl/tt_rob_region.sv
module tt_rob_region #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned TID   = 0,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_single,
    input  logic             mode_chg,
    input  logic             alloc_fire,
    input  logic             commit_fire,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             full,
    output logic             empty
);
    localparam int unsigned HALF = DEPTH / 2;

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
    } reg_t;

    reg_t st_d, st_q;
    logic [CNT_W-1:0] size;
    logic [IDX_W-1:0] base;

    always_comb begin
        if (mode_single) begin
            size = (TID == 0) ? CNT_W'(DEPTH) : '0;
            base = '0;
        end else begin
            size = CNT_W'(HALF);
            base = IDX_W'(TID * HALF);
        end
    end

    assign full     = (st_q.cnt >= size);
    assign empty    = (st_q.cnt == '0);
    assign head_idx = base + st_q.head;
    assign tail_idx = base + st_q.tail;

    always_comb begin
        st_d = st_q;
        if (mode_chg) begin
            st_d = '0;
        end else begin
            if (alloc_fire) begin
                st_d.tail = (CNT_W'(st_q.tail) == size - 1'b1) ? '0 : st_q.tail + 1'b1;
            end
            if (commit_fire) begin
                st_d.head = (CNT_W'(st_q.head) == size - 1'b1) ? '0 : st_q.head + 1'b1;
            end
            case ({alloc_fire, commit_fire})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tt_rob_status.sv
module tt_rob_status #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_fire,
    input  logic [IDX_W-1:0]   alloc_idx,
    input  logic               cmpl_valid,
    input  logic [IDX_W-1:0]   cmpl_idx,
    input  logic [1:0]         commit_fire,
    input  logic [2*IDX_W-1:0] commit_idx,
    output logic [DEPTH-1:0]   busy,
    output logic [DEPTH-1:0]   done
);
    typedef struct packed {
        logic [DEPTH-1:0] busy;
        logic [DEPTH-1:0] done;
    } reg_t;

    reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int e = 0; e < DEPTH; e++) begin
            if (cmpl_valid && cmpl_idx == IDX_W'(e) && st_q.busy[e]) begin
                st_d.done[e] = 1'b1;
            end
            for (int t = 0; t < 2; t++) begin
                if (commit_fire[t] && commit_idx[t*IDX_W +: IDX_W] == IDX_W'(e)) begin
                    st_d.busy[e] = 1'b0;
                    st_d.done[e] = 1'b0;
                end
            end
            if (alloc_fire && alloc_idx == IDX_W'(e)) begin
                st_d.busy[e] = 1'b1;
                st_d.done[e] = 1'b0;
            end
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.done;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tt_part_rob.sv
module tt_part_rob
    import tt_rob_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               single_mode,
    input  logic               alloc_valid,
    input  logic               alloc_tid,
    output logic               alloc_accept,
    output logic [IDX_W-1:0]   alloc_idx,
    input  logic               cmpl_valid,
    input  logic [IDX_W-1:0]   cmpl_idx,
    output logic [1:0]         commit_valid,
    output logic [2*IDX_W-1:0] commit_idx,
    output logic [1:0]         thr_full,
    output logic [1:0]         thr_empty
);
    typedef struct packed {
        rob_mode_e mode;
    } top_t;

    top_t st_d, st_q;
    logic mode_chg;
    logic [1:0] alloc_fire;
    logic [IDX_W-1:0] head_idx [ROB_THREADS];
    logic [IDX_W-1:0] tail_idx [ROB_THREADS];
    logic [DEPTH-1:0] busy, done;

    always_comb begin
        st_d = st_q;
        if (thr_empty == 2'b11 && !alloc_valid) begin
            st_d.mode = single_mode ? ROB_MODE_SINGLE : ROB_MODE_DUAL;
        end
    end
    assign mode_chg = (st_d.mode != st_q.mode);

    assign alloc_accept = alloc_valid && !thr_full[alloc_tid];
    assign alloc_idx    = tail_idx[alloc_tid];

    generate
        for (genvar t = 0; t < ROB_THREADS; t++) begin : g_thr
            assign alloc_fire[t]   = alloc_accept && (alloc_tid == 1'(t));
            assign commit_valid[t] = !thr_empty[t] && done[head_idx[t]];
            assign commit_idx[t*IDX_W +: IDX_W] = head_idx[t];

            tt_rob_region #(.DEPTH(DEPTH), .TID(t)) u_region (
                .clk         (clk),
                .rst_n       (rst_n),
                .mode_single (st_q.mode == ROB_MODE_SINGLE),
                .mode_chg    (mode_chg),
                .alloc_fire  (alloc_fire[t]),
                .commit_fire (commit_valid[t]),
                .head_idx    (head_idx[t]),
                .tail_idx    (tail_idx[t]),
                .full        (thr_full[t]),
                .empty       (thr_empty[t])
            );
        end
    endgenerate

    tt_rob_status #(.DEPTH(DEPTH)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_fire  (alloc_accept),
        .alloc_idx   (alloc_idx),
        .cmpl_valid  (cmpl_valid),
        .cmpl_idx    (cmpl_idx),
        .commit_fire (commit_valid),
        .commit_idx  (commit_idx),
        .busy        (busy),
        .done        (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: ROB_MODE_DUAL};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tt_part_rob_chk.sv
module tt_part_rob_chk #(
    parameter int unsigned IDX_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               alloc_valid,
    input logic               alloc_tid,
    input logic               alloc_accept,
    input logic [IDX_W-1:0]   alloc_idx,
    input logic [1:0]         commit_valid,
    input logic [1:0]         thr_full,
    input logic [1:0]         thr_empty,
    input logic               mode_q
);
    a_r2_refuse_full: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && thr_full[alloc_tid]) |-> !alloc_accept);

    a_r2_region_split: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_accept && !mode_q) |-> (alloc_idx[IDX_W-1] == alloc_tid));

    a_r3_commit_t0_held: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid[0] |-> !thr_empty[0]);

    a_r3_commit_t1_held: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid[1] |-> !thr_empty[1]);

    a_r6_t1_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (thr_full[1] && thr_empty[1] && !commit_valid[1]));

    a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_empty != 2'b11) |=> $stable(mode_q));
endmodule

bind tt_part_rob tt_part_rob_chk #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_tid    (alloc_tid),
    .alloc_accept (alloc_accept),
    .alloc_idx    (alloc_idx),
    .commit_valid (commit_valid),
    .thr_full     (thr_full),
    .thr_empty    (thr_empty),
    .mode_q       (st_q.mode)
);

// File: tb/tt_part_rob_bench.sv
module tt_part_rob_bench;
    localparam int DEPTH = 16;
    localparam int IW = 4;

    logic clk = 0, rst_n = 0;
    logic single_mode = 0, alloc_valid = 0, alloc_tid = 0, cmpl_valid = 0;
    logic alloc_accept;
    logic [IW-1:0] alloc_idx, cmpl_idx = 0;
    logic [1:0] commit_valid, thr_full, thr_empty;
    logic [2*IW-1:0] commit_idx;

    int checks = 0, fails = 0;
    int exp_tail [2];
    bit exp_single = 0;
    int q0 [$];
    int q1 [$];
    int seen [2];

    always #5 clk = ~clk;

    tt_part_rob #(.DEPTH(DEPTH)) u_tt_part_rob (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rbase(input int t);
        return exp_single ? 0 : t * (DEPTH / 2);
    endfunction
    function automatic int rsize(input int t);
        if (exp_single) return (t == 0) ? DEPTH : 0;
        return DEPTH / 2;
    endfunction

    // scoreboard monitor: every commit must match the oldest expected index
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            for (int t = 0; t < 2; t++) begin
                if (commit_valid[t]) begin
                    int got, want;
                    got = int'(commit_idx[t*IW +: IW]);
                    if (t == 0) want = (q0.size() > 0) ? q0.pop_front() : -1;
                    else        want = (q1.size() > 0) ? q1.pop_front() : -1;
                    seen[t]++;
                    chk(got == want, "R3 commit order", got, want);
                end
            end
        end
    end

    task automatic alloc(input int t, input bit exp_ok, input string req, output int idx);
        alloc_valid = 1; alloc_tid = 1'(t);
        #2;
        chk(alloc_accept == exp_ok, {req, " accept"}, alloc_accept, exp_ok);
        idx = int'(alloc_idx);
        if (exp_ok) begin
            chk(idx == rbase(t) + exp_tail[t], {req, " index"}, idx, rbase(t) + exp_tail[t]);
            exp_tail[t] = (exp_tail[t] == rsize(t) - 1) ? 0 : exp_tail[t] + 1;
            if (t == 0) q0.push_back(idx); else q1.push_back(idx);
        end
        @(negedge clk);
        alloc_valid = 0;
    endtask

    task automatic complete(input int idx);
        cmpl_valid = 1; cmpl_idx = IW'(idx);
        @(negedge clk);
        cmpl_valid = 0;
    endtask

    task automatic drain();
        int n = 0;
        while ((q0.size() > 0 || q1.size() > 0) && n < 100) begin
            @(negedge clk); n++;
        end
        @(negedge clk);
        chk(q0.size() == 0 && q1.size() == 0, "R3 drained", q0.size() + q1.size(), 0);
    endtask

    task automatic set_mode(input bit s);
        single_mode = s;
        @(negedge clk); @(negedge clk);
        exp_single = s;
        exp_tail[0] = 0; exp_tail[1] = 0;
    endtask

    initial begin
        int ids [16];
        int a, b, c, d, dummy, s0;
        exp_tail[0] = 0; exp_tail[1] = 0; seen[0] = 0; seen[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        chk(thr_empty == 2'b11, "R1 empty", thr_empty, 3);
        chk(thr_full == 2'b00, "R1 full", thr_full, 0);
        chk(commit_valid == 2'b00, "R1 commit", commit_valid, 0);
        @(negedge clk);

        // R2: fill thread 0 and thread 1, refuse beyond 8
        for (int i = 0; i < 8; i++) alloc(0, 1, "R2 t0 fill", ids[i]);
        #1; chk(thr_full[0] == 1, "R2 t0 full", thr_full[0], 1);
        chk(thr_full[1] == 0, "R2 t1 not full", thr_full[1], 0);
        alloc(0, 0, "R2 t0 refused", dummy);
        alloc(1, 1, "R2 t1 region", a);
        for (int i = 0; i < 8; i++) complete(ids[i]);
        complete(a);
        drain();

        // R8: thread 0 wraps back to index 0, thread 1 continues at 9
        alloc(0, 1, "R8 t0 wrap", a);
        chk(a == 0, "R8 wrapped index", a, 0);
        alloc(1, 1, "R8 t1 next", b);
        complete(a); complete(b);
        drain();

        // R3: younger entries done first do not commit
        alloc(0, 1, "R3 alloc", a);
        alloc(0, 1, "R3 alloc", b);
        alloc(0, 1, "R3 alloc", c);
        s0 = seen[0];
        complete(c); complete(b);
        repeat (3) @(negedge clk);
        chk(seen[0] == s0, "R3 held by head", seen[0], s0);
        complete(a);
        drain();
        chk(seen[0] == s0 + 3, "R3 all committed", seen[0], s0 + 3);

        // R4: blocked thread 0 head, thread 1 still commits
        alloc(0, 1, "R4 alloc t0", a);
        alloc(1, 1, "R4 alloc t1", b);
        s0 = seen[1];
        complete(b);
        repeat (2) @(negedge clk);
        chk(seen[1] == s0 + 1, "R4 t1 committed", seen[1], s0 + 1);
        #3; chk(commit_valid[0] == 0, "R4 t0 waits", commit_valid[0], 0);
        @(negedge clk);
        complete(a);
        drain();

        // R5: both threads commit in the same cycle
        alloc(0, 1, "R5 alloc", a);
        alloc(0, 1, "R5 alloc", b);
        alloc(1, 1, "R5 alloc", c);
        alloc(1, 1, "R5 alloc", d);
        complete(b); complete(d); complete(a); complete(c);
        #3; chk(commit_valid == 2'b11, "R5 dual commit", commit_valid, 3);
        drain();

        // R9: completion of an unallocated entry is ignored
        complete(rbase(1) + exp_tail[1]);
        alloc(1, 1, "R9 alloc", a);
        repeat (2) @(negedge clk);
        #3; chk(commit_valid[1] == 0, "R9 stale completion", commit_valid[1], 0);
        @(negedge clk);
        complete(a);
        drain();

        // R6: single mode gives thread 0 every entry
        set_mode(1);
        #1; chk(thr_full[1] == 1 && thr_empty[1] == 1, "R6 t1 blocked", thr_full[1], 1);
        @(negedge clk);
        alloc(1, 0, "R6 t1 refused", dummy);
        for (int i = 0; i < 16; i++) alloc(0, 1, "R6 t0 fill", ids[i]);
        chk(ids[15] == 15, "R6 last index", ids[15], 15);
        alloc(0, 0, "R6 t0 refused", dummy);

        // R7: mode request ignored while entries are held
        single_mode = 0;
        repeat (3) @(negedge clk);
        #1; chk(thr_full[1] == 1, "R7 mode frozen", thr_full[1], 1);
        @(negedge clk);
        for (int i = 0; i < 16; i++) complete(ids[i]);
        drain();
        repeat (2) @(negedge clk);
        exp_single = 0; exp_tail[0] = 0; exp_tail[1] = 0;
        #1; chk(thr_full[1] == 0, "R7 mode taken when empty", thr_full[1], 0);
        @(negedge clk);
        alloc(1, 1, "R8 restart after mode change", a);
        chk(a == 8, "R8 region restart", a, 8);
        complete(a);
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule